// File: doc/BRIEF.md
# Three-Wire Ident/Clock/Data Bus Slave

This block is the target end of a three-line serial control bus made up of an ident line, a bus clock and a shared open-drain data line. It runs on the local system clock and passes all three incoming lines through synchronisers. It then follows the bus sequence using edges on the synchronised ident and clock lines. While ident is low the master clocks in an address byte. When ident rises, the slave compares that byte with its own device tag.

A matching address picks one register of a small bank. The same byte fixes the transfer direction and the transfer length. Write data is assembled in a shift register and reaches the register bank only when ident pulses low briefly after the data phase. Read data is placed on the shared line by pulling it low for a zero and releasing it for a one. The bank contents drive the `regs_o` outputs, which control logic elsewhere on the chip.

Top module: `tw_slave`

## Requirements
- R1: After reset every register word reads zero on `regs_o` and the data line is released (`sdat_pull_o` low).
- R2: The address is taken from eight rising bus-clock edges while ident is low, first bit into address bit 0. It is evaluated on the rising edge of ident.
- R3: Address bit 0 selects the direction (1 = read, 0 = write). Bits 2:1 select register index 0 to 3. Bits 7:3 must equal the device tag 5'b10110, or the address does not match.
- R4: Registers 0 and 1 take 8-bit transfers and registers 2 and 3 take 16-bit transfers. Data moves least significant bit first. Bus-clock pulses beyond that length are ignored. The upper byte of an 8-bit register reads zero on `regs_o`.
- R5: Write data changes `regs_o` only when ident falls at the start of the closing low pulse after the data phase. The register is unchanged at any earlier point.
- R6: If the closing ident pulse comes before the full 8 or 16 bits have arrived, the write is discarded and the register keeps its old value.
- R7: On a read, each bit is on the line before the next rising bus-clock edge. A zero is a pulled-low line and a one is a released line. The line is released once the last bit has been sent.
- R8: On a non-matching address the line stays released, no register changes, and clock pulses are ignored until the next address phase.
- R9: An address phase with a number of clock pulses other than eight is treated as a non-match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ident_i | input | 1 | Ident line from the bus master, idle high |
| sclk_i | input | 1 | Bus clock line from the master, idle high |
| sdat_i | input | 1 | Level sensed on the shared data line |
| sdat_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_o | output | NUM_REGS*DATA_W | Register bank contents, word i at bits i*16 and up |

## Verification
The assertions assume that the bus lines change slowly compared with the system clock. Each synchronised edge must be seen as a separate event, and ident never moves in the same system cycle as the bus clock. The bench keeps every bus level constant for six system clocks and changes ident only while the bus clock is high. It also wires the data input as the AND of its own drive and the released slave output, so the slave always reads the real line level.

// File: rtl/tw_bus_pkg.sv
package tw_bus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_DATA  = 3'd2,
      ST_SKIP  = 3'd3,
      ST_CLOSE = 3'd4
   } tw_state_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '1;
         else if (s == 0) chain[s] <= d_i;
         else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/tw_addr_decode.sv
module tw_addr_decode #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned NUM_REGS    = 4,
   parameter int unsigned NARROW_REGS = 2,
   parameter int unsigned DEV_TAG     = 22
) (
   input  logic [ADDR_W-1:0]           addr_i,
   output logic                        hit_o,
   output logic                        rd_o,
   output logic                        wide_o,
   output logic [$clog2(NUM_REGS)-1:0] idx_o
);

   localparam int unsigned IDX_W = $clog2(NUM_REGS);
   localparam int unsigned TAG_W = ADDR_W - IDX_W - 1;
   localparam logic [TAG_W-1:0] TAG_L    = TAG_W'(DEV_TAG);
   localparam logic [IDX_W:0]   NARROW_L = (IDX_W + 1)'(NARROW_REGS);

   always_comb begin
      rd_o   = addr_i[0];
      idx_o  = addr_i[IDX_W:1];
      hit_o  = (addr_i[ADDR_W-1 -: TAG_W] == TAG_L);
      wide_o = ({1'b0, idx_o} >= NARROW_L);
   end

endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank #(
   parameter int unsigned NUM_REGS    = 4,
   parameter int unsigned NARROW_REGS = 2,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned NARROW_W    = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  logic [$clog2(NUM_REGS)-1:0]   widx_i,
   input  logic [DATA_W-1:0]             wdata_i,
   input  logic [$clog2(NUM_REGS)-1:0]   ridx_i,
   output logic [DATA_W-1:0]             rdata_o,
   output logic [NUM_REGS*DATA_W-1:0]    regs_o
);

   localparam int unsigned IDX_W = $clog2(NUM_REGS);

   logic [DATA_W-1:0] words [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      if (g < NARROW_REGS) begin : g_narrow
         logic [NARROW_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (we_i && widx_i == IDX_W'(g)) q <= wdata_i[NARROW_W-1:0];
         end
         assign words[g] = {{(DATA_W-NARROW_W){1'b0}}, q};
      end else begin : g_wide
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (we_i && widx_i == IDX_W'(g)) q <= wdata_i;
         end
         assign words[g] = q;
      end
      assign regs_o[g*DATA_W +: DATA_W] = words[g];
   end

   assign rdata_o = words[ridx_i];

endmodule

// File: rtl/tw_slave.sv
module tw_slave #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned NARROW_W    = 8,
   parameter int unsigned NUM_REGS    = 4,
   parameter int unsigned NARROW_REGS = 2,
   parameter int unsigned DEV_TAG     = 22,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ident_i,
   input  logic                       sclk_i,
   input  logic                       sdat_i,
   output logic                       sdat_pull_o,
   output logic [NUM_REGS*DATA_W-1:0] regs_o
);
   import tw_bus_pkg::*;

   localparam int unsigned IDX_W   = $clog2(NUM_REGS);
   localparam int unsigned MAX_LEN = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
   localparam int unsigned CNT_W   = $clog2(MAX_LEN + 2);
   localparam logic [CNT_W-1:0] ADDR_CNT = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0] NAR_CNT  = CNT_W'(NARROW_W);
   localparam logic [CNT_W-1:0] WIDE_CNT = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tw_slave: SYNC_STAGES must be at least 2");
   end
   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
      $error("tw_slave: NUM_REGS must be a power of two, at least 2");
   end
   if (NARROW_REGS > NUM_REGS || NARROW_W > DATA_W) begin : g_bad_narrow
      $error("tw_slave: narrow register settings out of range");
   end
   if (ADDR_W <= IDX_W + 1) begin : g_bad_addr
      $error("tw_slave: ADDR_W leaves no room for a device tag");
   end

   // line synchronisers and edge detection
   logic [2:0] raw_lines, sync_lines;
   logic       id_lvl, ck_lvl, sd_lvl, id_prev, ck_prev;
   logic       id_rise, id_fall, ck_rise, ck_fall;

   assign raw_lines = {ident_i, sclk_i, sdat_i};

   tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lines),
      .q_o   (sync_lines)
   );

   assign {id_lvl, ck_lvl, sd_lvl} = sync_lines;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_prev <= 1'b1;
         ck_prev <= 1'b1;
      end else begin
         id_prev <= id_lvl;
         ck_prev <= ck_lvl;
      end
   end

   assign id_rise = id_lvl & ~id_prev;
   assign id_fall = ~id_lvl & id_prev;
   assign ck_rise = ck_lvl & ~ck_prev;
   assign ck_fall = ~ck_lvl & ck_prev;

   // transfer state
   tw_state_e         st;
   logic [CNT_W-1:0]  cnt, cnt_inc, width_now;
   logic [ADDR_W-1:0] ash;
   logic [DATA_W-1:0] wsh, rsh, bank_rdata, commit_data;
   logic              cur_rd, cur_wide, commit_en, addr_ok;
   logic [IDX_W-1:0]  cur_idx, dec_idx;
   logic              dec_hit, dec_rd, dec_wide;

   tw_addr_decode #(
      .ADDR_W      (ADDR_W),
      .NUM_REGS    (NUM_REGS),
      .NARROW_REGS (NARROW_REGS),
      .DEV_TAG     (DEV_TAG)
   ) u_dec (
      .addr_i (ash),
      .hit_o  (dec_hit),
      .rd_o   (dec_rd),
      .wide_o (dec_wide),
      .idx_o  (dec_idx)
   );

   assign addr_ok   = dec_hit && (cnt == ADDR_CNT);
   assign cnt_inc   = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
   assign width_now = cur_wide ? WIDE_CNT : NAR_CNT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         ash      <= '0;
         wsh      <= '0;
         rsh      <= '0;
         cur_rd   <= 1'b0;
         cur_wide <= 1'b0;
         cur_idx  <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (id_fall) begin
                  st  <= ST_ADDR;
                  cnt <= '0;
               end
            end
            ST_ADDR: begin
               if (id_rise) begin
                  if (addr_ok) begin
                     st       <= ST_DATA;
                     cnt      <= '0;
                     cur_rd   <= dec_rd;
                     cur_wide <= dec_wide;
                     cur_idx  <= dec_idx;
                     rsh      <= bank_rdata;
                     wsh      <= '0;
                  end else begin
                     st <= ST_SKIP;
                  end
               end else if (ck_rise) begin
                  ash <= {sd_lvl, ash[ADDR_W-1:1]};
                  cnt <= cnt_inc;
               end
            end
            ST_DATA: begin
               if (id_fall) begin
                  st <= ST_CLOSE;
               end else if (ck_rise && cnt < width_now) begin
                  cnt <= cnt + 1'b1;
                  if (!cur_rd) wsh <= {sd_lvl, wsh[DATA_W-1:1]};
               end else if (ck_fall && cur_rd && cnt != '0 && cnt < width_now) begin
                  rsh <= {1'b0, rsh[DATA_W-1:1]};
               end
            end
            ST_SKIP: begin
               if (id_fall) st <= ST_CLOSE;
            end
            ST_CLOSE: begin
               if (id_rise) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign commit_en   = (st == ST_DATA) && id_fall && !cur_rd && (cnt == width_now);
   assign commit_data = cur_wide ? wsh
                                 : {{(DATA_W-NARROW_W){1'b0}}, wsh[DATA_W-1 -: NARROW_W]};
   assign sdat_pull_o = (st == ST_DATA) && cur_rd && (cnt < width_now) && !rsh[0];

   tw_reg_bank #(
      .NUM_REGS    (NUM_REGS),
      .NARROW_REGS (NARROW_REGS),
      .DATA_W      (DATA_W),
      .NARROW_W    (NARROW_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (commit_en),
      .widx_i  (cur_idx),
      .wdata_i (commit_data),
      .ridx_i  (dec_idx),
      .rdata_o (bank_rdata),
      .regs_o  (regs_o)
   );

endmodule

// File: rtl/tw_slave_chk.sv
module tw_slave_chk
   import tw_bus_pkg::*;
#(
   parameter int unsigned CNT_W  = 5,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned REGS_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tw_state_e         st,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              pull,
   input  logic              commit_en,
   input  logic [REGS_W-1:0] regs
);

   // R2: a data phase is only ever entered straight from an address phase
   a_r2_data_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && $past(st) != ST_DATA) |-> $past(st) == ST_ADDR);

   // R4: the data-phase bit counter never runs past the widest transfer
   a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA) |-> cnt <= CNT_W'(DATA_W));

   // R5: register outputs move only one cycle after a commit strobe
   a_r5_change_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs) |-> $past(commit_en));

   // R7: the line is released once the full word has been sent
   a_r7_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && cnt == CNT_W'(DATA_W)) |-> !pull);

   // R8: an unselected slave neither drives nor commits
   a_r8_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP || st == ST_IDLE) |-> (!pull && !commit_en));

endmodule

bind tw_slave tw_slave_chk #(
   .CNT_W  (CNT_W),
   .DATA_W (DATA_W),
   .REGS_W (NUM_REGS*DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st        (st),
   .cnt       (cnt),
   .pull      (sdat_pull_o),
   .commit_en (commit_en),
   .regs      (regs_o)
);

// File: tb/test_tw_slave.sv
module test_tw_slave;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ident = 1'b1;
   logic        sclk = 1'b1;
   logic        drv = 1'b1;
   logic        pull;
   logic        sdat;
   logic [63:0] regs;

   int compared = 0;
   int mismatched = 0;
   localparam int HP = 6;

   always #10 clk = ~clk;

   assign sdat = drv & ~pull;

   tw_slave i_tw_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .ident_i     (ident),
      .sclk_i      (sclk),
      .sdat_i      (sdat),
      .sdat_pull_o (pull),
      .regs_o      (regs)
   );

   // vector: {is_read, addr[7:0], nbits[4:0], wdata[15:0], reg_idx[1:0], expected[15:0]}
   localparam int NV = 12;
   localparam logic [47:0] VEC [NV] = '{
      {1'b0, 8'hB0, 5'd8,  16'h005A, 2'd0, 16'h005A},
      {1'b0, 8'hB4, 5'd16, 16'hA5C3, 2'd2, 16'hA5C3},
      {1'b0, 8'hB6, 5'd16, 16'h1234, 2'd3, 16'h1234},
      {1'b0, 8'hB2, 5'd8,  16'h00FF, 2'd1, 16'h00FF},
      {1'b1, 8'hB1, 5'd8,  16'h0000, 2'd0, 16'h005A},
      {1'b1, 8'hB5, 5'd16, 16'h0000, 2'd2, 16'hA5C3},
      {1'b1, 8'hB7, 5'd16, 16'h0000, 2'd3, 16'h1234},
      {1'b0, 8'hB0, 5'd4,  16'h000F, 2'd0, 16'h005A},
      {1'b0, 8'h30, 5'd8,  16'h0077, 2'd0, 16'h005A},
      {1'b0, 8'hB2, 5'd16, 16'hBEEF, 2'd1, 16'h00EF},
      {1'b1, 8'hB3, 5'd8,  16'h0000, 2'd1, 16'h00EF},
      {1'b0, 8'hB4, 5'd16, 16'h0001, 2'd2, 16'h0001}
   };

   function automatic logic [15:0] word(input int idx);
      return regs[idx*16 +: 16];
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hold();
      repeat (HP) @(negedge clk);
   endtask

   task automatic send_addr(input logic [7:0] a, input int n);
      ident = 1'b0;
      hold();
      for (int i = 0; i < n; i++) begin
         sclk = 1'b0;
         drv  = a[i];
         hold();
         sclk = 1'b1;
         hold();
      end
      drv   = 1'b1;
      ident = 1'b1;
      hold();
   endtask

   task automatic xfer(input logic [15:0] w, input int n, input logic rd,
                       output logic [15:0] got, output logic stray);
      got   = '0;
      stray = 1'b0;
      for (int i = 0; i < n; i++) begin
         sclk = 1'b0;
         drv  = rd ? 1'b1 : w[i];
         hold();
         if (rd) got[i] = sdat;
         else if (pull) stray = 1'b1;
         sclk = 1'b1;
         hold();
      end
      drv = 1'b1;
      hold();
   endtask

   task automatic close_pulse();
      ident = 1'b0;
      hold();
      ident = 1'b1;
      hold();
      hold();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [15:0] got;
      logic        stray;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      hold();

      // R1: reset state
      for (int r = 0; r < 4; r++) check("R1 reset word", word(r), 16'h0000);
      check("R1 line released after reset", {15'd0, pull}, 16'h0000);

      // table walk: R2 R3 R4 R5 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         logic        is_rd;
         logic [7:0]  a;
         logic [4:0]  nb;
         logic [15:0] wd, ex;
         logic [1:0]  ix;
         {is_rd, a, nb, wd, ix, ex} = VEC[v];
         send_addr(a, 8);
         xfer(wd, int'(nb), is_rd, got, stray);
         if (is_rd) begin
            check($sformatf("R7 read vector %0d data", v), got, ex);
            check($sformatf("R7 read vector %0d released after last bit", v),
                  {15'd0, pull}, 16'h0000);
         end else begin
            check($sformatf("R8 write vector %0d line released", v), {15'd0, stray}, 16'h0000);
         end
         close_pulse();
         check($sformatf("R2 R3 R4 R5 R6 vector %0d register", v), word(int'(ix)), ex);
      end

      // R5: no effect before the closing pulse
      send_addr(8'hB6, 8);
      xfer(16'hCAFE, 16, 1'b0, got, stray);
      check("R5 register unchanged before closing pulse", word(3), 16'h1234);
      close_pulse();
      check("R5 register written on closing pulse", word(3), 16'hCAFE);

      // R9: seven-bit address phase does not select
      send_addr(8'hB0, 7);
      xfer(16'h0033, 8, 1'b0, got, stray);
      close_pulse();
      check("R9 short address leaves register", word(0), 16'h005A);

      // R8: foreign tag read never drives the line
      send_addr(8'h31, 8);
      xfer(16'h0000, 8, 1'b1, got, stray);
      check("R8 foreign read line stays high", got, 16'h00FF);
      close_pulse();
      check("R8 foreign read leaves register", word(0), 16'h005A);

      // R4: extra clocks on a narrow read come back released
      send_addr(8'hB3, 8);
      xfer(16'h0000, 12, 1'b1, got, stray);
      close_pulse();
      check("R4 narrow read with extra clocks", got, 16'h0FEF);

      // R6: short wide write discarded
      send_addr(8'hB4, 8);
      xfer(16'hFFFF, 15, 1'b0, got, stray);
      close_pulse();
      check("R6 fifteen-bit write discarded", word(2), 16'h0001);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule